// File: doc/BRIEF.md
# Progressive Clock Ramp Divider

This block produces the clock-enable strobe for a system clock derived from a fast PLL output clock, and runs entirely in that fast domain. When the system clock source is switched over to the PLL, a sudden jump to full PLL rate could cause a sharp step in supply current. To avoid that step, the block ramps the strobe rate in stages. It starts at one pulse every eight fast cycles, then moves to one every four, then one every two, and finally asserts the enable on every cycle. The downstream clock gating cell therefore sees a load that rises in steps, and the voltage regulator can follow it.

The ramp is armed by a control bit. With the bit clear, selecting the PLL moves the block straight to full rate. The source-select input arrives asynchronously. It passes through a two-flop synchronizer, and a rising edge of the synchronized value starts the ramp. When the select input falls, at any point, the block returns to idle. The next rising edge starts a new ramp from the slowest stage. A two-bit stage code and a done flag report where the ramp stands.

Top module: `pll_ramp_divider`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and at its release, `ce_o` is 0, `stage_o` is 0 and `done_o` is 0.
- R2: `sel_i` passes through a two-flop synchronizer. If `sel_i` is set high just after a clock edge, the outputs stay idle for the first two edges that follow. The first ramp cycle (stage 0) begins after the third edge.
- R3: With ramp mode armed, `stage_o` steps through the codes 0 (divide by 8), 1 (divide by 4), 2 (divide by 2) and 3 (full rate). Stage 0 lasts 8 fast cycles, stage 1 lasts 16 and stage 2 lasts 32, each counted from the start of that stage. Stage 3 is therefore reached 56 cycles after the ramp begins.
- R4: In a divided stage with ratio N, `ce_o` is a single-cycle pulse in the last cycle of every group of N cycles, counted from the start of that stage. The first pulse of a stage falls in that stage's N-th cycle.
- R5: In stage 3, `ce_o` is high on every cycle and `done_o` is high. `done_o` is low in every other state.
- R6: With ramp mode disarmed (`ramp_en_i` = 0 at the synchronized rising edge), the block goes directly to stage 3 in the first cycle after the edge.
- R7: `ramp_en_i` is sampled only at the synchronized rising edge of the select input. Changing it during a ramp, or while at full rate, does not alter the stage sequence or the strobe.
- R8: If `sel_i` falls, the block is idle three edges later (`ce_o` = 0, `stage_o` = 0, `done_o` = 0) and stays idle while the select is low. The next rising edge restarts the ramp at stage 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast PLL output clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ramp_en_i | input | 1 | Arms the progressive ramp (1) or selects a direct switch to full rate (0) |
| sel_i | input | 1 | Asynchronous PLL source select; a rising edge starts the ramp |
| ce_o | output | 1 | Clock-enable strobe for the system clock |
| stage_o | output | 2 | Current stage: 0 = /8, 1 = /4, 2 = /2, 3 = full rate (0 when idle) |
| done_o | output | 1 | High while the block is at full rate |

## Verification
The bound checker enforces several rules on every cycle. The strobe and the done flag are never active while idle. A strobe never arrives sooner than the current stage's period after the previous strobe or after the ramp start. Stage codes only step upward by one. The done state always carries a strobe. A low synchronized select always leads to idle on the next cycle. The exact stage lengths, the phase of the first pulse in each stage, the synchronizer latency and the effect of the enable bit are left to the bench. The bench sweeps the point at which the select falls across the whole ramp and beyond, and compares every cycle against an arithmetic model of the 8/16/32-cycle schedule.

// File: rtl/pll_ramp_pkg.sv
package pll_ramp_pkg;

    localparam int STAGE_W  = 2;
    localparam int N_DIV    = 3;

    typedef logic [STAGE_W-1:0] stage_code_t;

    typedef enum logic [2:0] {
        RS_IDLE = 3'd0,
        RS_DIV8 = 3'd1,
        RS_DIV4 = 3'd2,
        RS_DIV2 = 3'd3,
        RS_FULL = 3'd4
    } ramp_state_e;

    localparam stage_code_t STG_DIV8 = 2'd0;
    localparam stage_code_t STG_DIV4 = 2'd1;
    localparam stage_code_t STG_DIV2 = 2'd2;
    localparam stage_code_t STG_FULL = 2'd3;

    // divide ratio of divided stage i (0 = slowest)
    function automatic int div_ratio(input int idx);
        return 8 >> idx;
    endfunction

endpackage

// File: rtl/pll_ramp_sync.sv
module pll_ramp_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    typedef struct packed {
        logic [DEPTH-1:0] chain;
    } sync_regs_t;

    sync_regs_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[DEPTH-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign q_o = s_q.chain[DEPTH-1];

endmodule

// File: rtl/pll_ramp_edge.sv
module pll_ramp_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic rise_o
);

    typedef struct packed {
        logic prev;
    } edge_regs_t;

    edge_regs_t e_d, e_q;

    always_comb begin
        e_d      = e_q;
        e_d.prev = lvl_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign rise_o = lvl_i & ~e_q.prev;

endmodule

// File: rtl/pll_ramp_seq.sv
module pll_ramp_seq
    import pll_ramp_pkg::*;
#(
    parameter int LEN_DIV8 = 8,
    parameter int LEN_DIV4 = 16,
    parameter int LEN_DIV2 = 32,
    parameter int CNT_W    = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sel_lvl_i,
    input  logic              sel_rise_i,
    input  logic              ramp_en_i,
    output ramp_state_e       state_o,
    output logic [CNT_W-1:0]  cnt_o
);

    localparam logic [CNT_W-1:0] LAST_DIV8 = CNT_W'(LEN_DIV8 - 1);
    localparam logic [CNT_W-1:0] LAST_DIV4 = CNT_W'(LEN_DIV4 - 1);
    localparam logic [CNT_W-1:0] LAST_DIV2 = CNT_W'(LEN_DIV2 - 1);

    typedef struct packed {
        ramp_state_e      state;
        logic [CNT_W-1:0] cnt;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    // advance within a divided stage, moving on after its last cycle
    function automatic seq_regs_t step_stage(input seq_regs_t cur,
                                             input logic [CNT_W-1:0] last,
                                             input ramp_state_e nxt);
        seq_regs_t res;
        res = cur;
        if (cur.cnt == last) begin
            res.state = nxt;
            res.cnt   = '0;
        end else begin
            res.cnt   = cur.cnt + 1'b1;
        end
        return res;
    endfunction

    always_comb begin
        r_d = r_q;
        if (!sel_lvl_i) begin
            r_d.state = RS_IDLE;
            r_d.cnt   = '0;
        end else begin
            unique case (r_q.state)
                RS_IDLE: begin
                    if (sel_rise_i) begin
                        r_d.state = ramp_en_i ? RS_DIV8 : RS_FULL;
                        r_d.cnt   = '0;
                    end
                end
                RS_DIV8: r_d = step_stage(r_q, LAST_DIV8, RS_DIV4);
                RS_DIV4: r_d = step_stage(r_q, LAST_DIV4, RS_DIV2);
                RS_DIV2: r_d = step_stage(r_q, LAST_DIV2, RS_FULL);
                RS_FULL: r_d.cnt = '0;
                default: begin
                    r_d.state = RS_IDLE;
                    r_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state <= RS_IDLE;
            r_q.cnt   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;
    assign cnt_o   = r_q.cnt;

endmodule

// File: rtl/pll_ramp_strobe.sv
module pll_ramp_strobe
    import pll_ramp_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  ramp_state_e      state_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             ce_o,
    output stage_code_t      stage_o,
    output logic             done_o
);

    logic [N_DIV-1:0] phase_hit;

    // one terminal-phase detector per divided stage
    for (genvar i = 0; i < N_DIV; i++) begin : g_phase
        localparam logic [CNT_W-1:0] MASK = CNT_W'(div_ratio(i) - 1);
        assign phase_hit[i] = ((cnt_i & MASK) == MASK);
    end

    always_comb begin
        ce_o    = 1'b0;
        stage_o = STG_DIV8;
        done_o  = 1'b0;
        unique case (state_i)
            RS_IDLE: begin
                ce_o    = 1'b0;
                stage_o = STG_DIV8;
            end
            RS_DIV8: begin
                ce_o    = phase_hit[0];
                stage_o = STG_DIV8;
            end
            RS_DIV4: begin
                ce_o    = phase_hit[1];
                stage_o = STG_DIV4;
            end
            RS_DIV2: begin
                ce_o    = phase_hit[2];
                stage_o = STG_DIV2;
            end
            RS_FULL: begin
                ce_o    = 1'b1;
                stage_o = STG_FULL;
                done_o  = 1'b1;
            end
            default: begin
                ce_o    = 1'b0;
                stage_o = STG_DIV8;
            end
        endcase
    end

endmodule

// File: rtl/pll_ramp_divider.sv
module pll_ramp_divider
    import pll_ramp_pkg::*;
#(
    parameter int SYNC_DEPTH = 2,
    parameter int LEN_DIV8   = 8,
    parameter int LEN_DIV4   = 16,
    parameter int LEN_DIV2   = 32
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ramp_en_i,
    input  logic       sel_i,
    output logic       ce_o,
    output logic [1:0] stage_o,
    output logic       done_o
);

    localparam int LEN_MAX_A = (LEN_DIV8 > LEN_DIV4) ? LEN_DIV8 : LEN_DIV4;
    localparam int LEN_MAX   = (LEN_MAX_A > LEN_DIV2) ? LEN_MAX_A : LEN_DIV2;
    localparam int CNT_W     = (LEN_MAX > 2) ? $clog2(LEN_MAX) : 1;

    logic             sel_sync;
    logic             sel_rise;
    ramp_state_e      seq_state;
    logic [CNT_W-1:0] seq_cnt;
    logic             ramp_active;
    stage_code_t      stage_code;

    pll_ramp_sync #(
        .DEPTH (SYNC_DEPTH)
    ) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (sel_i),
        .q_o    (sel_sync)
    );

    pll_ramp_edge edge_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (sel_sync),
        .rise_o (sel_rise)
    );

    pll_ramp_seq #(
        .LEN_DIV8 (LEN_DIV8),
        .LEN_DIV4 (LEN_DIV4),
        .LEN_DIV2 (LEN_DIV2),
        .CNT_W    (CNT_W)
    ) seq_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sel_lvl_i  (sel_sync),
        .sel_rise_i (sel_rise),
        .ramp_en_i  (ramp_en_i),
        .state_o    (seq_state),
        .cnt_o      (seq_cnt)
    );

    pll_ramp_strobe #(
        .CNT_W (CNT_W)
    ) strobe_i (
        .state_i (seq_state),
        .cnt_i   (seq_cnt),
        .ce_o    (ce_o),
        .stage_o (stage_code),
        .done_o  (done_o)
    );

    assign stage_o     = stage_code;
    assign ramp_active = (seq_state != RS_IDLE);

endmodule

// File: rtl/pll_ramp_divider_chk.sv
module pll_ramp_divider_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       sel_sync,
    input logic       active,
    input logic       ce_o,
    input logic [1:0] stage_o,
    input logic       done_o
);

    // cycles since the last strobe or since leaving idle, current cycle included
    logic [3:0] gap_q;
    logic [3:0] need;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gap_q <= 4'd1;
        end else if (!active || ce_o) begin
            gap_q <= 4'd1;
        end else if (gap_q != 4'hF) begin
            gap_q <= gap_q + 4'd1;
        end
    end

    assign need = 4'd8 >> stage_o;

    // R4: strobe spacing never shorter than the current stage's period
    assert_min_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ce_o && active && stage_o != 2'd3) |-> (gap_q >= need));

    // R5: full-rate state strobes every cycle and reports stage 3
    assert_full_rate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (ce_o && stage_o == 2'd3));

    // R8: idle keeps every output quiet
    assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active |-> (!ce_o && !done_o && stage_o == 2'd0));

    // R8: a low synchronized select forces idle on the next cycle
    assert_fall_to_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_sync |=> !active);

    // R3: within a ramp the stage code only steps up by one
    assert_stage_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active && $past(active) && stage_o != $past(stage_o))
            |-> (stage_o == $past(stage_o) + 2'd1));

endmodule

bind pll_ramp_divider pll_ramp_divider_chk chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_sync (sel_sync),
    .active   (ramp_active),
    .ce_o     (ce_o),
    .stage_o  (stage_o),
    .done_o   (done_o)
);

// File: tb/pll_ramp_divider_tb_top.sv
module pll_ramp_divider_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ramp_en = 1'b1;
    logic       sel = 1'b0;
    logic       ce;
    logic [1:0] stage;
    logic       done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pll_ramp_divider dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .ramp_en_i (ramp_en),
        .sel_i     (sel),
        .ce_o      (ce),
        .stage_o   (stage),
        .done_o    (done)
    );

    task automatic check(input string req, input bit ok, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
        end
    endtask

    task automatic expect_idle(input string req);
        check(req, ce == 1'b0, int'(ce), 0);
        check(req, stage == 2'd0, int'(stage), 0);
        check(req, done == 1'b0, int'(done), 0);
    endtask

    // expected outputs at cycle k of a ramp (k = 0 is the first stage-0 cycle)
    task automatic expect_k(input int k, input bit armed, input string tag);
        bit         e_ce;
        logic [1:0] e_st;
        bit         e_dn;
        string      rs;
        string      rc;
        if (!armed) begin
            e_ce = 1'b1; e_st = 2'd3; e_dn = 1'b1;
            rs = "R6"; rc = "R6";
        end else if (k < 8) begin
            e_ce = (k % 8) == 7; e_st = 2'd0; e_dn = 1'b0;
            rs = "R3"; rc = "R4";
        end else if (k < 24) begin
            e_ce = ((k - 8) % 4) == 3; e_st = 2'd1; e_dn = 1'b0;
            rs = "R3"; rc = "R4";
        end else if (k < 56) begin
            e_ce = ((k - 24) % 2) == 1; e_st = 2'd2; e_dn = 1'b0;
            rs = "R3"; rc = "R4";
        end else begin
            e_ce = 1'b1; e_st = 2'd3; e_dn = 1'b1;
            rs = "R5"; rc = "R5";
        end
        if (tag != "") begin
            rs = tag; rc = tag;
        end
        check(rc, ce == e_ce, int'(ce), int'(e_ce));
        check(rs, stage == e_st, int'(stage), int'(e_st));
        check(rs, done == e_dn, int'(done), int'(e_dn));
    endtask

    // raise select, follow the ramp to cycle fall_at, drop select, check return to idle
    task automatic run_ramp(input int fall_at, input bit armed, input int toggle_at, input string tag);
        @(negedge clk);
        ramp_en = armed;
        sel = 1'b1;
        @(negedge clk);
        expect_idle("R2");
        @(negedge clk);
        expect_idle("R2");
        for (int k = 0; k <= fall_at + 2; k++) begin
            @(negedge clk);
            expect_k(k, armed, tag);
            if (k == toggle_at) ramp_en = ~ramp_en;
            if (k == fall_at) sel = 1'b0;
        end
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            expect_idle("R8");
        end
        ramp_en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        expect_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        expect_idle("R1");
        repeat (3) @(negedge clk);
        expect_idle("R1");

        // R3 R4 R5 R8: sweep the fall point across and past the ramp
        for (int f = 0; f <= 62; f++) begin
            run_ramp(f, 1'b1, -1, "");
        end

        // R6: direct switch when ramp mode is disarmed
        run_ramp(3, 1'b0, -1, "");
        run_ramp(20, 1'b0, -1, "");

        // R7: enable changes after the edge have no effect
        run_ramp(40, 1'b1, 5, "R7");
        run_ramp(60, 1'b1, 57, "R7");
        run_ramp(12, 1'b0, 2, "R7");

        // R8: a long quiet period, then a restart from stage 0
        repeat (20) @(negedge clk);
        expect_idle("R8");
        run_ramp(10, 1'b1, -1, "R8");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule